// File: doc/BRIEF.md
# Arithmetic-Code Self-Checking Adder

This block adds two unsigned operands and checks its own result with an arithmetic code that survives addition. One of three checking schemes is picked on each transfer. In the multiplier scheme each operand is scaled by three (formed as a one-place shift plus the operand itself), the scaled values are added, and the total must still divide evenly by three. In the residue scheme each operand carries a small check value equal to the operand modulo m = 2^RW − 1. The two check values are added modulo m on their own and compared with the residue recomputed from the main sum. The complemented-residue scheme carries m − R in place of R.

Residues are computed cheaply by summing RW-bit slices of a value with an end-around carry. The carry out of the main add is kept, so the check covers the full sum. All outputs are registered and appear one cycle after the input strobe. A fault mask input flips bits of the raw adder output before the check. It models a defect in the adder datapath so that the error flag can be exercised.

Top module: `acr_checked_adder`

## Requirements
- R1: While rst_n is low, and until the first accepted transfer, valid_o, err_o, sum_o and code_o are all zero.
- R2: valid_o equals valid_i delayed by one clock. In a cycle after valid_i was low, sum_o and code_o keep their previous values and err_o is low.
- R3: With fault_i zero, sum_o is a_i + b_i as a DW+1 bit value including the carry, in every mode.
- R4: Mode 2'b00 selects the multiplier scheme. code_o holds W = (3·a_i + 3·b_i) XOR fault_i in its low DW+3 bits, with zeros above. sum_o is floor(W/3) truncated to DW+1 bits.
- R5: In mode 2'b00, err_o is set exactly when W is not a multiple of 3. Because of this, a fault that shifts W by a multiple of 3 is not flagged.
- R6: Mode 2'b01 selects the residue scheme. code_o is {S, R}. S = (a_i + b_i) XOR fault_i[DW:0] fills the upper DW+1 bits and is also sum_o. R = (a_i + b_i) mod m fills the low RW bits and lies in 0..m−1.
- R7: In residue modes, err_o is set exactly when S mod m differs from (a_i + b_i) mod m. Bits of fault_i above bit DW have no effect.
- R8: Mode 2'b10 selects the complemented-residue scheme. Its low RW bits hold m − R, so a residue of 0 is stored as m (all ones). Its sum and error behaviour follow R6 and R7.
- R9: Mode 2'b11 behaves exactly as mode 2'b01.
- R10: With fault_i zero, err_o never rises in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands present this cycle |
| mode_i | input | 2 | Checking scheme: 00 multiplier-3, 01 residue, 10 complemented residue, 11 residue |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand |
| fault_i | input | DW+3 | Bit flips applied to the raw adder output before checking |
| valid_o | output | 1 | Result registers updated |
| sum_o | output | DW+1 | Decoded sum with carry |
| code_o | output | DW+1+RW | Code word of the sum |
| err_o | output | 1 | Code check failed |

## Verification
The operands include all-zero, all-ones with a full carry, sums whose residue is exactly zero, and mixed values. These show whether the carry bit enters the code and whether a residue of m is normalised to zero (or stored as m in the complemented scheme). Single-bit faults must be flagged in every scheme. Faults worth a multiple of 3 or of m must not be flagged, which confirms the check tests code membership and does not compare against a shadow adder. A fault above the residue sum width and idle cycles with changing operands show that ignored inputs leave the outputs untouched.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    ACR_MUL3    = 2'b00,
    ACR_RES     = 2'b01,
    ACR_RES_INV = 2'b10,
    ACR_RES_ALT = 2'b11
  } acr_mode_e;
endpackage

// File: rtl/acr_fold.sv
// Residue modulo 2^B-1 by end-around-carry summation of B-bit slices.
module acr_fold #(
  parameter int W = 16,
  parameter int B = 4
) (
  input  logic [W-1:0] val_i,
  output logic [B-1:0] res_o
);
  localparam int NS = (W + B - 1) / B;
  localparam int PW = NS * B;

  logic [PW-1:0] padded;
  logic [B:0]    acc;

  assign padded = PW'(val_i);

  always_comb begin
    acc = '0;
    for (int i = 0; i < NS; i++) begin
      acc = acc + {1'b0, padded[i*B +: B]};
      acc = {1'b0, acc[B-1:0]} + {{B{1'b0}}, acc[B]};
    end
  end

  // all-ones is the second representation of zero
  assign res_o = (acc[B-1:0] == {B{1'b1}}) ? '0 : acc[B-1:0];
endmodule

// File: rtl/acr_mul3_path.sv
// Multiplier-3 code: encode both operands, add, test divisibility by 3.
module acr_mul3_path #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW+2:0] fault_i,
  output logic [DW+2:0] word_o,
  output logic [DW:0]   sum_o,
  output logic          err_o
);
  localparam int EW = DW + 2;
  localparam int WW = DW + 3;

  logic [EW-1:0] enc_a, enc_b;
  logic [WW-1:0] raw;
  logic [1:0]    rem3;
  logic [WW-1:0] quot;

  // 3N formed as N shifted left by one plus N
  assign enc_a = {1'b0, a_i, 1'b0} + EW'(a_i);
  assign enc_b = {1'b0, b_i, 1'b0} + EW'(b_i);
  assign raw   = ({1'b0, enc_a} + {1'b0, enc_b}) ^ fault_i;

  acr_fold #(.W(WW), .B(2)) u_mod3 (
    .val_i (raw),
    .res_o (rem3)
  );

  assign quot   = raw / WW'(3);
  assign word_o = raw;
  assign sum_o  = quot[DW:0];
  assign err_o  = (rem3 != 2'd0);
endmodule

// File: rtl/acr_res_path.sv
// Residue and complemented-residue code over the full DW+1 bit sum.
module acr_res_path #(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW:0]   fault_i,
  input  logic          inv_i,
  output logic [DW:0]   sum_o,
  output logic [RW-1:0] field_o,
  output logic          err_o
);
  localparam logic [RW-1:0] MOD = {RW{1'b1}};

  logic [DW:0]   sum_raw;
  logic [RW-1:0] res_a, res_b, res_sum;
  logic [RW-1:0] cmp_a, cmp_b;
  logic [RW-1:0] pred_dir, pred_cmp, pred_r;

  assign sum_raw = ({1'b0, a_i} + {1'b0, b_i}) ^ fault_i;

  acr_fold #(.W(DW), .B(RW)) u_fold_a (.val_i(a_i), .res_o(res_a));
  acr_fold #(.W(DW), .B(RW)) u_fold_b (.val_i(b_i), .res_o(res_b));
  acr_fold #(.W(DW+1), .B(RW)) u_fold_s (.val_i(sum_raw), .res_o(res_sum));

  // check values as they travel with the operands in the complemented scheme
  assign cmp_a = MOD - res_a;
  assign cmp_b = MOD - res_b;

  // separate modulo-m adders for the check values
  acr_fold #(.W(RW+1), .B(RW)) u_add_dir (
    .val_i ({1'b0, res_a} + {1'b0, res_b}),
    .res_o (pred_dir)
  );
  acr_fold #(.W(RW+1), .B(RW)) u_add_cmp (
    .val_i ({1'b0, cmp_a} + {1'b0, cmp_b}),
    .res_o (pred_cmp)
  );

  always_comb begin
    if (inv_i) begin
      // sum of complements is the negated residue
      pred_r  = (pred_cmp == '0) ? '0 : (MOD - pred_cmp);
      field_o = MOD - pred_r;
    end else begin
      pred_r  = pred_dir;
      field_o = pred_dir;
    end
  end

  assign sum_o = sum_raw;
  assign err_o = (res_sum != pred_r);
endmodule

// File: rtl/acr_checked_adder.sv
module acr_checked_adder
  import acr_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [DW-1:0]      a_i,
  input  logic [DW-1:0]      b_i,
  input  logic [DW+2:0]      fault_i,
  output logic               valid_o,
  output logic [DW:0]        sum_o,
  output logic [DW+RW:0]     code_o,
  output logic               err_o
);
  localparam int CW = DW + 1 + RW;

  acr_mode_e     mode;
  logic [DW+2:0] m3_word;
  logic [DW:0]   m3_sum;
  logic          m3_err;
  logic [DW:0]   rs_sum;
  logic [RW-1:0] rs_field;
  logic          rs_err;
  logic          is_inv;

  logic          valid_d, err_d;
  logic [DW:0]   sum_d;
  logic [CW-1:0] code_d;
  logic          valid_q, err_q;
  logic [DW:0]   sum_q;
  logic [CW-1:0] code_q;

  assign mode   = acr_mode_e'(mode_i);
  assign is_inv = (mode == ACR_RES_INV);

  acr_mul3_path #(.DW(DW)) u_mul3 (
    .a_i     (a_i),
    .b_i     (b_i),
    .fault_i (fault_i),
    .word_o  (m3_word),
    .sum_o   (m3_sum),
    .err_o   (m3_err)
  );

  acr_res_path #(.DW(DW), .RW(RW)) u_res (
    .a_i     (a_i),
    .b_i     (b_i),
    .fault_i (fault_i[DW:0]),
    .inv_i   (is_inv),
    .sum_o   (rs_sum),
    .field_o (rs_field),
    .err_o   (rs_err)
  );

  // next state
  always_comb begin
    valid_d = valid_i;
    err_d   = 1'b0;
    sum_d   = sum_q;
    code_d  = code_q;
    if (valid_i) begin
      if (mode == ACR_MUL3) begin
        sum_d  = m3_sum;
        code_d = CW'(m3_word);
        err_d  = m3_err;
      end else begin
        sum_d  = rs_sum;
        code_d = {rs_sum, rs_field};
        err_d  = rs_err;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      sum_q   <= '0;
      code_q  <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      sum_q   <= sum_d;
      code_q  <= code_d;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign sum_o   = sum_q;
  assign code_o  = code_q;
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_i,
  input logic [1:0]     mode_i,
  input logic [DW-1:0]  a_i,
  input logic [DW-1:0]  b_i,
  input logic [DW+2:0]  fault_i,
  input logic           valid_o,
  input logic [DW:0]    sum_o,
  input logic [DW+RW:0] code_o,
  input logic           err_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);  // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(sum_o) && $stable(code_o)));  // R2
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);  // R2
  AST_CLEAN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fault_i == '0) |=>
      (sum_o == ($past({1'b0, a_i}) + $past({1'b0, b_i}))));  // R3
  AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fault_i == '0) |=> !err_o);  // R10
  AST_RES_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 2'b01) |=> (code_o[RW-1:0] != {RW{1'b1}}));  // R6
  AST_INV_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == 2'b10) |=> (code_o[RW-1:0] != '0));  // R8
endmodule

bind acr_checked_adder acr_checker #(.DW(DW), .RW(RW)) u_acr_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .fault_i (fault_i),
  .valid_o (valid_o),
  .sum_o   (sum_o),
  .code_o  (code_o),
  .err_o   (err_o)
);

// File: tb/acr_checked_adder_bench.sv
`timescale 1ns/100ps
module acr_checked_adder_bench;
  localparam int DW  = 16;
  localparam int RW  = 4;
  localparam int CW  = DW + 1 + RW;
  localparam longint MOD   = (64'd1 << RW) - 1;
  localparam longint SMASK = (64'd1 << (DW + 1)) - 1;
  localparam longint DMASK = (64'd1 << DW) - 1;

  logic           clk;
  logic           rst_n;
  logic           valid_i;
  logic [1:0]     mode_i;
  logic [DW-1:0]  a_i, b_i;
  logic [DW+2:0]  fault_i;
  logic           valid_o;
  logic [DW:0]    sum_o;
  logic [CW-1:0]  code_o;
  logic           err_o;

  int checks;
  int failures;
  bit done;

  acr_checked_adder #(.DW(DW), .RW(RW)) u_acr_checked_adder (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .fault_i (fault_i),
    .valid_o (valid_o),
    .sum_o   (sum_o),
    .code_o  (code_o),
    .err_o   (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Apply one transfer and check the registered result one cycle later.
  task automatic xfer(input string req, input logic [1:0] mode, input longint a,
                      input longint b, input longint fault);
    longint w, f, s, r, fld, e_sum, e_code, e_err;
    @(negedge clk);
    valid_i = 1'b1;
    mode_i  = mode;
    a_i     = DW'(a);
    b_i     = DW'(b);
    fault_i = (DW+3)'(fault);
    if (mode == 2'b00) begin
      w      = (3 * (a & DMASK) + 3 * (b & DMASK)) ^ fault;
      e_code = w;
      e_sum  = (w / 3) & SMASK;
      e_err  = (w % 3 != 0) ? 1 : 0;
    end else begin
      s      = (a & DMASK) + (b & DMASK);
      f      = (s ^ fault) & SMASK;
      r      = s % MOD;
      fld    = (mode == 2'b10) ? (MOD - r) : r;
      e_sum  = f;
      e_code = (f << RW) | fld;
      e_err  = ((f % MOD) != r) ? 1 : 0;
    end
    @(posedge clk);
    #1;
    valid_i = 1'b0;
    check({req, " valid"}, longint'(valid_o), 1);
    check({req, " sum"},   longint'(sum_o), e_sum);
    check({req, " code"},  longint'(code_o), e_code);
    check({req, " err"},   longint'(err_o), e_err);
  endtask

  task automatic t_reset;
    check("R1 valid", longint'(valid_o), 0);
    check("R1 sum",   longint'(sum_o), 0);
    check("R1 code",  longint'(code_o), 0);
    check("R1 err",   longint'(err_o), 0);
  endtask

  task automatic t_mul3;
    xfer("R4 zero",     2'b00, 0, 0, 0);
    xfer("R4 allones",  2'b00, 'hFFFF, 'hFFFF, 0);
    xfer("R3 R4 mixed", 2'b00, 'h1234, 'h5678, 0);
    xfer("R4 carry",    2'b00, 'hFFFF, 1, 0);
    xfer("R5 flip1",    2'b00, 'h0100, 'h0020, 'h1);
    xfer("R5 flip_top", 2'b00, 'hABCD, 'h1111, 'h40000);
    xfer("R5 alias3",   2'b00, 0, 0, 'h3);
  endtask

  task automatic t_res;
    xfer("R6 zero",      2'b01, 0, 0, 0);
    xfer("R6 res_m",     2'b01, 7, 8, 0);
    xfer("R3 R6 carry",  2'b01, 'hFFFF, 'hFFFF, 0);
    xfer("R6 mixed",     2'b01, 'h1234, 'h5678, 0);
    xfer("R7 flip5",     2'b01, 'h1234, 'h0042, 'h20);
    xfer("R7 flipcarry", 2'b01, 'h8000, 'h8000, 'h10000);
    xfer("R7 aliasm",    2'b01, 0, 0, 'hF);
    xfer("R7 highbits",  2'b01, 'h0F0F, 'h1111, 'h60000);
  endtask

  task automatic t_inv;
    xfer("R8 zero",     2'b10, 0, 0, 0);
    xfer("R8 mixed",    2'b10, 'h1234, 'h5678, 0);
    xfer("R8 allones",  2'b10, 'hFFFF, 'hFFFF, 0);
    xfer("R8 res_m",    2'b10, 'h00F0, 'h000F, 0);
    xfer("R8 flip",     2'b10, 'h4321, 'h0101, 'h100);
  endtask

  task automatic t_alt;
    xfer("R9 mixed",   2'b11, 'h2468, 'h1357, 0);
    xfer("R9 flip",    2'b11, 'h2468, 'h1357, 'h2);
  endtask

  task automatic t_hold;
    longint s0, c0;
    xfer("R2 load", 2'b01, 'h0A0A, 'h0505, 'h1);
    s0 = longint'(sum_o);
    c0 = longint'(code_o);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      a_i     = DW'(i * 'h1111 + 3);
      b_i     = DW'(i * 'h0777);
      mode_i  = 2'(i);
      fault_i = (DW+3)'(i + 1);
      @(posedge clk);
      #1;
      check("R2 idle valid", longint'(valid_o), 0);
      check("R2 idle err",   longint'(err_o), 0);
      check("R2 hold sum",   longint'(sum_o), s0);
      check("R2 hold code",  longint'(code_o), c0);
    end
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    valid_i  = 1'b0;
    mode_i   = 2'b00;
    a_i      = '0;
    b_i      = '0;
    fault_i  = '0;
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_mul3();
    t_res();
    t_inv();
    t_alt();
    t_hold();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule